// File: doc/BRIEF.md
# Scanning Two-Port Memory Viewer

This block holds a 32-word by 4-bit store with two independent address paths. One path reads and the other writes. A free-running scan counter drives the read path. It dwells on each location for a programmable number of clock cycles and then moves to the next one, wrapping after the last word. With the default count at 50 MHz, each dwell lasts about one second. The current read address and the word stored there are presented together, so a display stage can show both.

The write path takes an address, a data word and a write request from asynchronous, switch-style sources. Each is first brought into the clock domain through a two-stage synchronizer. A rising edge on the synchronized request stores the synchronized data at the synchronized address, once per press, at any moment. The synchronized write address and data are also exposed.

Reset is asynchronous and active low, and its release is synchronized inside the block. Reset returns the dwell counter and the scan address to zero. It leaves the stored words untouched.

Top module: `scan_mem_viewer`

## Requirements
- R1: While reset is asserted, and for at least the first dwell period after release, `rd_addr` reads 0.
- R2: After the first step, `rd_addr` advances by exactly one every `TICK_CYCLES` clock cycles and holds steady in between.
- R3: The scan wraps from address 31 back to address 0 and continues.
- R4: `rd_data` always shows the word stored at the address currently on `rd_addr`, in the same cycle, with no further delay.
- R5: A write request held high stores one word only: the data present at its rising edge. Data changed while the request stays high is not stored.
- R6: Changing the write address or data while the request is low alters no stored word.
- R7: `wr_addr_sync` and `wr_data_sync` equal the asynchronous inputs as they were two clock edges earlier.
- R8: A rising request edge writes the synchronized data at the synchronized address, and every address 0 to 31 can be written.
- R9: Reset does not clear the stored words. Contents written before a reset are scanned out unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_addr | input | 5 | Asynchronous write address |
| sw_wr_data | input | 4 | Asynchronous write data |
| sw_wr_req | input | 1 | Asynchronous write request, level; its rising edge writes |
| rd_addr | output | 5 | Address currently being scanned |
| rd_data | output | 4 | Word stored at `rd_addr` |
| wr_addr_sync | output | 5 | Write address after synchronization |
| wr_data_sync | output | 4 | Write data after synchronization |

## Verification
The synchronized write fields are due two edges after an input changes. The bench samples them one edge later to confirm they have not yet changed, and again after the second edge to confirm they have. A request edge reaches the store on the third edge after it appears at the input. The bench therefore holds each write for several cycles and updates its reference model only after the request is released, and it skips data checks for the whole write window so that an address collision is never judged. `rd_addr` changes one edge after the internal scan step, and `rd_data` follows it combinationally. Every change of `rd_addr`, sampled on the falling edge, is checked for its step size, for the interval since the previous change, and for the stored word against the model.

// File: rtl/scanmem_pkg.sv
package scanmem_pkg;
  localparam int unsigned DEF_ADDR_W = 5;
  localparam int unsigned DEF_DATA_W = 4;
  localparam int unsigned DEF_TICK   = 50_000_000;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/smv_rst_sync.sv
module smv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_sync = rs_q[1];
endmodule

// File: rtl/smv_sync_bus.sv
module smv_sync_bus #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = scanmem_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) stage_q[s] <= d_async;
      end else begin : g_rest
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/smv_scan_gen.sv
module smv_scan_gen #(
  parameter int unsigned ADDR_W      = scanmem_pkg::DEF_ADDR_W,
  parameter int unsigned TICK_CYCLES = scanmem_pkg::DEF_TICK
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    tick   = (cnt_q == LAST);
    cnt_d  = cnt_q + CW'(1);
    addr_d = addr_q;
    if (tick) begin
      cnt_d  = '0;
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign scan_addr = addr_q;
endmodule

// File: rtl/smv_dp_ram.sv
module smv_dp_ram #(
  parameter int unsigned ADDR_W = scanmem_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = scanmem_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] raddr_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raddr_q <= '0;
    else        raddr_q <= raddr;
  end

  assign rdata = mem[raddr_q];
endmodule

// File: rtl/scan_mem_viewer.sv
module scan_mem_viewer #(
  parameter int unsigned ADDR_W      = scanmem_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W      = scanmem_pkg::DEF_DATA_W,
  parameter int unsigned TICK_CYCLES = scanmem_pkg::DEF_TICK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sw_wr_addr,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              sw_wr_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] wr_addr_sync,
  output logic [DATA_W-1:0] wr_data_sync
);
  logic              rst_n_i;
  logic              req_s, req_q, wr_pulse;
  logic [ADDR_W-1:0] scan_addr;
  logic              scan_tick;

  smv_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  smv_sync_bus #(.W(ADDR_W)) u_sync_addr (.clk(clk), .d_async(sw_wr_addr), .d_sync(wr_addr_sync));
  smv_sync_bus #(.W(DATA_W)) u_sync_data (.clk(clk), .d_async(sw_wr_data), .d_sync(wr_data_sync));
  smv_sync_bus #(.W(1))      u_sync_req  (.clk(clk), .d_async(sw_wr_req),  .d_sync(req_s));

  // rising-edge detect: one write per press
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) req_q <= 1'b0;
    else          req_q <= req_s;
  end
  assign wr_pulse = req_s & ~req_q;

  smv_scan_gen #(.ADDR_W(ADDR_W), .TICK_CYCLES(TICK_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_n_i), .scan_addr(scan_addr), .tick(scan_tick)
  );

  smv_dp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n_i), .we(wr_pulse), .waddr(wr_addr_sync),
    .wdata(wr_data_sync), .raddr(scan_addr), .raddr_q(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/scan_mem_viewer_chk.sv
module scan_mem_viewer_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] scan_addr,
  input logic              scan_tick,
  input logic              wr_pulse,
  input logic [ADDR_W-1:0] sw_wr_addr,
  input logic [ADDR_W-1:0] wr_addr_sync,
  input logic [DATA_W-1:0] sw_wr_data,
  input logic [DATA_W-1:0] wr_data_sync
);
  // R2, R3: any step of the exposed address is +1 modulo depth
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != $past(rd_addr)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1)));

  // R2: scan address holds between ticks
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(scan_addr));

  // R5: a write pulse never lasts beyond one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R7: synchronized fields lag the inputs by two edges
  a_r7_addr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr_sync == $past(sw_wr_addr, 2));
  a_r7_data_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_sync == $past(sw_wr_data, 2));
endmodule

bind scan_mem_viewer scan_mem_viewer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .scan_addr(scan_addr),
  .scan_tick(scan_tick), .wr_pulse(wr_pulse), .sw_wr_addr(sw_wr_addr),
  .wr_addr_sync(wr_addr_sync), .sw_wr_data(sw_wr_data), .wr_data_sync(wr_data_sync)
);

// File: tb/tb_scan_mem_viewer.sv
module tb_scan_mem_viewer;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int TICK = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] sw_wr_addr;
  logic [DW-1:0] sw_wr_data;
  logic sw_wr_req;
  logic [AW-1:0] rd_addr, wr_addr_sync;
  logic [DW-1:0] rd_data, wr_data_sync;

  always #2.5 clk = ~clk;

  scan_mem_viewer #(.ADDR_W(AW), .DATA_W(DW), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_addr(sw_wr_addr), .sw_wr_data(sw_wr_data),
    .sw_wr_req(sw_wr_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_addr_sync(wr_addr_sync), .wr_data_sync(wr_data_sync)
  );

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [DEPTH];
  bit valid [DEPTH];
  bit busy = 1'b0;
  string cur_tag = "R4";
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // scan monitor
  int cyc = 0, last_chg = 0;
  bit seen_chg = 0;
  logic [AW-1:0] prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; seen_chg = 0; prev = rd_addr;
    end else begin
      cyc++;
      if (rd_addr != prev) begin
        if (seen_chg) chk(cyc - last_chg == TICK, "R2", cyc - last_chg, TICK);
        chk(rd_addr == AW'(prev + 1), (prev == AW'(DEPTH-1)) ? "R3" : "R2",
            int'(rd_addr), int'(AW'(prev + 1)));
        last_chg = cyc; seen_chg = 1;
        if (!busy && valid[rd_addr])
          chk(rd_data == model[rd_addr], cur_tag, int'(rd_data), int'(model[rd_addr]));
        prev = rd_addr;
      end
    end
  end

  task automatic press(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busy = 1;
    @(negedge clk); sw_wr_addr = a; sw_wr_data = d;
    repeat (3) @(negedge clk); sw_wr_req = 1'b1;
    repeat (4) @(negedge clk); sw_wr_req = 1'b0;
    repeat (3) @(negedge clk);
    model[a] = d; valid[a] = 1;
    busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_wr_addr = '0; sw_wr_data = '0; sw_wr_req = 1'b0;
    for (int i = 0; i < DEPTH; i++) valid[i] = 0;
    repeat (5) @(negedge clk);
    chk(rd_addr == 0, "R1", rd_addr, 0);
    rst_n = 1'b1;
    repeat (TICK - 1) @(negedge clk);
    chk(rd_addr == 0, "R1", rd_addr, 0);

    // R7 latency of the synchronizers
    sw_wr_addr = 5'h15; sw_wr_data = 4'hA;
    @(negedge clk);
    chk(wr_addr_sync == 5'h00, "R7", wr_addr_sync, 0);
    chk(wr_data_sync == 4'h0, "R7", wr_data_sync, 0);
    @(negedge clk);
    chk(wr_addr_sync == 5'h15, "R7", wr_addr_sync, 5'h15);
    chk(wr_data_sync == 4'hA, "R7", wr_data_sync, 4'hA);

    // R8: fill every address
    cur_tag = "R8";
    for (int a = 0; a < DEPTH; a++) press(AW'(a), DW'((a * 7 + 3) % 16));
    repeat (2 * DEPTH * TICK + 10) @(negedge clk);

    // R5: data changed while request held is not stored
    cur_tag = "R5";
    busy = 1;
    @(negedge clk); sw_wr_addr = 5'd9; sw_wr_data = 4'h5;
    repeat (3) @(negedge clk); sw_wr_req = 1'b1;
    repeat (4) @(negedge clk); sw_wr_data = 4'hE;
    repeat (6) @(negedge clk); sw_wr_req = 1'b0;
    repeat (3) @(negedge clk);
    model[9] = 4'h5; busy = 0;
    repeat (DEPTH * TICK + 10) @(negedge clk);

    // R6: switches move without a request
    cur_tag = "R6";
    sw_wr_addr = 5'd9; sw_wr_data = 4'hC;
    repeat (5) @(negedge clk);
    sw_wr_addr = 5'd20; sw_wr_data = 4'h1;
    repeat (DEPTH * TICK + 10) @(negedge clk);

    // R4: overwrite ends and a middle word
    cur_tag = "R4";
    press(5'd0, 4'hF);
    press(5'd31, 4'h0);
    press(5'd16, 4'h9);
    repeat (DEPTH * TICK + 10) @(negedge clk);

    // R9: contents survive reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_addr == 0, "R1", rd_addr, 0);
    rst_n = 1'b1;
    cur_tag = "R9";
    repeat (TICK - 1) @(negedge clk);
    chk(rd_addr == 0, "R1", rd_addr, 0);
    repeat (DEPTH * TICK + 10) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule